// File: doc/BRIEF.md
# Special-Purpose Register Access Unit

This block serves the move-to and move-from special-register operations of a small 32-bit RISC core. The core hands it a base operand, a 16-bit immediate, write data, the old value of the destination register, and read and write strobes. The block forms the register number and selects the addressed register. It returns read data combinationally. Each write is applied on the next rising clock edge, under the update rule that belongs to the target register.

The registers held here fall into four sets. There is a small group of system registers: machine status, next PC, previous PC, exception PC, exception address and exception status. There is a 64-bit multiply-accumulate register, reached through two 32-bit halves. Two interrupt-controller words hold the mask and the pending status. A few read-only identification constants complete the set. A status write that changes a protection-related bit raises a one-cycle flush request for the translation logic. The stored values are also driven out as ports so the rest of the core can use them.

Top module: `spr_unit`

## Requirements
- R1: The register number is `base_i | imm_i`, a bitwise OR and not a sum. Bits 15:11 of the number give the group and bits 10:0 give the index, so the number equals group*2048 + index. Any number with a nonzero bit in 31:16 is unmapped.
- R2: Five group-0 numbers read constants: 0 (version), 1 (unit present, default 0x00000619), 2 (CPU config, default 0x00000020), 3 (data-MMU config, default 0x00000018) and 4 (instruction-MMU config, default 0x00000018). The version read returns the version value ANDed with a field mask. With the defaults (value 0x12AB00C7, mask 0xFF00003F) it reads 0x12000007.
- R3: Six group-0 numbers hold 32-bit read/write registers: 16 next PC, 17 status, 18 previous PC, 32 exception PC, 48 exception address and 64 exception status. A write is seen on the matching output port and on reads from the cycle after the write edge.
- R4: Number 0x2801 (group 5, index 1) reads and writes bits 31:0 of the 64-bit accumulator. Number 0x2802 (group 5, index 2) reads and writes bits 63:32. A write to one half leaves the other half unchanged.
- R5: A write to number 0x4800 (group 9, index 0) ORs the data into the interrupt mask. Mask bits can be set but never cleared.
- R6: A write to number 0x4802 (group 9, index 2) clears every pending bit that is 1 in the data. Every cycle, `irq_set_i` ORs new pending bits in, and a set in the same cycle wins over a clear.
- R7: `flush_o` is high for exactly the one cycle after a status write edge that changes bit 0 (supervisor), bit 5 (data-MMU enable) or bit 6 (instruction-MMU enable). It stays low for all other writes.
- R8: A read of an unmapped number, or any cycle with `rd_en_i` low, returns `prev_rd_i`. Writes to unmapped or read-only numbers change no state.
- R9: A synchronous active-high reset sets status to 0x00000001 (supervisor, both MMUs off). It clears every other stored register and `flush_o`.
- R10: `rdata_o` depends combinationally on the current inputs. A read and a write to the same number in the same cycle returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en_i | input | 1 | Move-from strobe |
| wr_en_i | input | 1 | Move-to strobe |
| base_i | input | 32 | Base operand of the register number |
| imm_i | input | 16 | Immediate offset of the register number |
| wdata_i | input | 32 | Move-to data |
| prev_rd_i | input | 32 | Old destination value, passed through on a miss |
| irq_set_i | input | 32 | Interrupt sources that raise pending bits |
| rdata_o | output | 32 | Move-from result |
| flush_o | output | 1 | One-cycle translation flush request |
| sr_o | output | 32 | Status register |
| npc_o | output | 32 | Next PC register |
| ppc_o | output | 32 | Previous PC register |
| epcr_o | output | 32 | Exception PC register |
| eear_o | output | 32 | Exception address register |
| esr_o | output | 32 | Exception status register |
| mac_o | output | 64 | Accumulator |
| pic_mask_o | output | 32 | Interrupt mask |
| pic_stat_o | output | 32 | Interrupt pending status |

## Verification
The bench drives directed sequences and then a long mix drawn from mapped, read-only and unmapped numbers, with random data and random interrupt sources.

- A base/immediate pair whose OR and sum name different registers shows whether the address is formed by OR or by addition.
- Repeated mask writes with sparse patterns show whether the mask is OR-set or overwritten.
- Clears that overlap with live interrupt sources show the set-wins rule.
- Status writes that touch only unprotected bits, compared with writes that flip one protected bit, show whether the flush is tied to the right bits.

// File: rtl/spr_pkg.sv
package spr_pkg;

    localparam int unsigned XLEN    = 32;
    localparam int unsigned ACC_W   = 2 * XLEN;
    localparam int unsigned NUM_W   = 16;
    localparam int unsigned GRP_LSB = 11;
    localparam int unsigned N_PLAIN = 5;

    localparam int unsigned SR_SUP_BIT  = 0;
    localparam int unsigned SR_DMMU_BIT = 5;
    localparam int unsigned SR_IMMU_BIT = 6;
    localparam logic [XLEN-1:0] SR_GUARD =
        (XLEN'(1) << SR_SUP_BIT) | (XLEN'(1) << SR_DMMU_BIT) | (XLEN'(1) << SR_IMMU_BIT);
    localparam logic [XLEN-1:0] SR_RESET = XLEN'(1) << SR_SUP_BIT;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_VER,
        SEL_UNITS,
        SEL_CPUCFG,
        SEL_DCFG,
        SEL_ICFG,
        SEL_NPC,
        SEL_STAT,
        SEL_PPC,
        SEL_EPC,
        SEL_EADDR,
        SEL_ESTAT,
        SEL_ACC_LO,
        SEL_ACC_HI,
        SEL_IMASK,
        SEL_IPEND
    } spr_sel_e;

    typedef struct packed {
        logic            wr;
        spr_sel_e        sel;
        logic [XLEN-1:0] data;
    } spr_wr_t;

    function automatic logic [NUM_W-1:0] spr_num(input int unsigned grp, input int unsigned idx);
        return NUM_W'((grp << GRP_LSB) + idx);
    endfunction

    localparam logic [NUM_W-1:0] N_VER    = spr_num(0, 0);
    localparam logic [NUM_W-1:0] N_UNITS  = spr_num(0, 1);
    localparam logic [NUM_W-1:0] N_CPUCFG = spr_num(0, 2);
    localparam logic [NUM_W-1:0] N_DCFG   = spr_num(0, 3);
    localparam logic [NUM_W-1:0] N_ICFG   = spr_num(0, 4);
    localparam logic [NUM_W-1:0] N_NPC    = spr_num(0, 16);
    localparam logic [NUM_W-1:0] N_STAT   = spr_num(0, 17);
    localparam logic [NUM_W-1:0] N_PPC    = spr_num(0, 18);
    localparam logic [NUM_W-1:0] N_EPC    = spr_num(0, 32);
    localparam logic [NUM_W-1:0] N_EADDR  = spr_num(0, 48);
    localparam logic [NUM_W-1:0] N_ESTAT  = spr_num(0, 64);
    localparam logic [NUM_W-1:0] N_ACC_LO = spr_num(5, 1);
    localparam logic [NUM_W-1:0] N_ACC_HI = spr_num(5, 2);
    localparam logic [NUM_W-1:0] N_IMASK  = spr_num(9, 0);
    localparam logic [NUM_W-1:0] N_IPEND  = spr_num(9, 2);

    function automatic spr_sel_e spr_lookup(input logic [XLEN-1:0] num);
        spr_sel_e s;
        s = SEL_NONE;
        if (num[XLEN-1:NUM_W] == '0) begin
            case (num[NUM_W-1:0])
                N_VER:    s = SEL_VER;
                N_UNITS:  s = SEL_UNITS;
                N_CPUCFG: s = SEL_CPUCFG;
                N_DCFG:   s = SEL_DCFG;
                N_ICFG:   s = SEL_ICFG;
                N_NPC:    s = SEL_NPC;
                N_STAT:   s = SEL_STAT;
                N_PPC:    s = SEL_PPC;
                N_EPC:    s = SEL_EPC;
                N_EADDR:  s = SEL_EADDR;
                N_ESTAT:  s = SEL_ESTAT;
                N_ACC_LO: s = SEL_ACC_LO;
                N_ACC_HI: s = SEL_ACC_HI;
                N_IMASK:  s = SEL_IMASK;
                N_IPEND:  s = SEL_IPEND;
                default:  s = SEL_NONE;
            endcase
        end
        return s;
    endfunction

    // Order of the plain read/write registers inside the system bank.
    function automatic spr_sel_e plain_sel(input int unsigned i);
        case (i)
            0:       return SEL_NPC;
            1:       return SEL_PPC;
            2:       return SEL_EPC;
            3:       return SEL_EADDR;
            default: return SEL_ESTAT;
        endcase
    endfunction

endpackage

// File: rtl/spr_decode.sv
module spr_decode
    import spr_pkg::*;
#(
    parameter int unsigned IMM_W = 16
) (
    input  logic [XLEN-1:0]  base_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic             wr_en_i,
    input  logic [XLEN-1:0]  wdata_i,
    output spr_sel_e         sel_o,
    output spr_wr_t          wr_o
);
    logic [XLEN-1:0] num;

    // Register number is an OR of the operands, never an addition.
    assign num   = base_i | XLEN'(imm_i);
    assign sel_o = spr_lookup(num);

    always_comb begin
        wr_o.wr   = wr_en_i && (sel_o != SEL_NONE);
        wr_o.sel  = sel_o;
        wr_o.data = wdata_i;
    end
endmodule

// File: rtl/spr_sys_regs.sv
module spr_sys_regs
    import spr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  spr_wr_t         wr_i,
    output logic [XLEN-1:0] stat_o,
    output logic [XLEN-1:0] plain_o [N_PLAIN],
    output logic            flush_o
);
    logic [XLEN-1:0] stat_q;
    logic            flush_q;
    logic            stat_hit;
    logic            guard_change;

    assign stat_hit     = wr_i.wr && (wr_i.sel == SEL_STAT);
    assign guard_change = ((stat_q ^ wr_i.data) & SR_GUARD) != '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q  <= SR_RESET;
            flush_q <= 1'b0;
        end else begin
            flush_q <= stat_hit && guard_change;
            if (stat_hit) stat_q <= wr_i.data;
        end
    end

    for (genvar i = 0; i < N_PLAIN; i++) begin : g_plain
        localparam spr_sel_e MY_SEL = plain_sel(i);
        logic [XLEN-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)                                  q <= '0;
            else if (wr_i.wr && (wr_i.sel == MY_SEL)) q <= wr_i.data;
        end
        assign plain_o[i] = q;
    end

    assign stat_o  = stat_q;
    assign flush_o = flush_q;
endmodule

// File: rtl/spr_acc_regs.sv
module spr_acc_regs
    import spr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  spr_wr_t          wr_i,
    output logic [ACC_W-1:0] acc_o
);
    localparam int unsigned N_HALF = ACC_W / XLEN;
    logic [XLEN-1:0] half_q [N_HALF];

    for (genvar h = 0; h < N_HALF; h++) begin : g_half
        localparam spr_sel_e MY_SEL = (h == 0) ? SEL_ACC_LO : SEL_ACC_HI;
        always_ff @(posedge clk) begin
            if (rst)                                  half_q[h] <= '0;
            else if (wr_i.wr && (wr_i.sel == MY_SEL)) half_q[h] <= wr_i.data;
        end
        assign acc_o[h*XLEN +: XLEN] = half_q[h];
    end
endmodule

// File: rtl/spr_pic_regs.sv
module spr_pic_regs
    import spr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  spr_wr_t         wr_i,
    input  logic [XLEN-1:0] irq_set_i,
    output logic [XLEN-1:0] mask_o,
    output logic [XLEN-1:0] pend_o
);
    logic [XLEN-1:0] mask_q;
    logic [XLEN-1:0] pend_q;
    logic [XLEN-1:0] clr;

    assign clr = (wr_i.wr && (wr_i.sel == SEL_IPEND)) ? wr_i.data : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            pend_q <= '0;
        end else begin
            if (wr_i.wr && (wr_i.sel == SEL_IMASK)) mask_q <= mask_q | wr_i.data;
            pend_q <= (pend_q & ~clr) | irq_set_i;
        end
    end

    assign mask_o = mask_q;
    assign pend_o = pend_q;
endmodule

// File: rtl/spr_unit.sv
module spr_unit
    import spr_pkg::*;
#(
    parameter int unsigned     IMM_W      = 16,
    parameter logic [XLEN-1:0] VER_VALUE  = 32'h12AB_00C7,
    parameter logic [XLEN-1:0] VER_MASK   = 32'hFF00_003F,
    parameter logic [XLEN-1:0] UNITS_CFG  = 32'h0000_0619,
    parameter logic [XLEN-1:0] CPU_CFG    = 32'h0000_0020,
    parameter logic [XLEN-1:0] DMMU_CFG   = 32'h0000_0018,
    parameter logic [XLEN-1:0] IMMU_CFG   = 32'h0000_0018
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [XLEN-1:0]   base_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [XLEN-1:0]   wdata_i,
    input  logic [XLEN-1:0]   prev_rd_i,
    input  logic [XLEN-1:0]   irq_set_i,
    output logic [XLEN-1:0]   rdata_o,
    output logic              flush_o,
    output logic [XLEN-1:0]   sr_o,
    output logic [XLEN-1:0]   npc_o,
    output logic [XLEN-1:0]   ppc_o,
    output logic [XLEN-1:0]   epcr_o,
    output logic [XLEN-1:0]   eear_o,
    output logic [XLEN-1:0]   esr_o,
    output logic [ACC_W-1:0]  mac_o,
    output logic [XLEN-1:0]   pic_mask_o,
    output logic [XLEN-1:0]   pic_stat_o
);
    spr_sel_e        sel;
    spr_wr_t         wr;
    logic [XLEN-1:0] plain [N_PLAIN];

    spr_decode #(.IMM_W(IMM_W)) u_dec (
        .base_i  (base_i),
        .imm_i   (imm_i),
        .wr_en_i (wr_en_i),
        .wdata_i (wdata_i),
        .sel_o   (sel),
        .wr_o    (wr)
    );

    spr_sys_regs u_sys (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (wr),
        .stat_o  (sr_o),
        .plain_o (plain),
        .flush_o (flush_o)
    );

    spr_acc_regs u_acc (
        .clk   (clk),
        .rst   (rst),
        .wr_i  (wr),
        .acc_o (mac_o)
    );

    spr_pic_regs u_pic (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (wr),
        .irq_set_i (irq_set_i),
        .mask_o    (pic_mask_o),
        .pend_o    (pic_stat_o)
    );

    assign npc_o  = plain[0];
    assign ppc_o  = plain[1];
    assign epcr_o = plain[2];
    assign eear_o = plain[3];
    assign esr_o  = plain[4];

    always_comb begin
        rdata_o = prev_rd_i;
        if (rd_en_i) begin
            case (sel)
                SEL_VER:    rdata_o = VER_VALUE & VER_MASK;
                SEL_UNITS:  rdata_o = UNITS_CFG;
                SEL_CPUCFG: rdata_o = CPU_CFG;
                SEL_DCFG:   rdata_o = DMMU_CFG;
                SEL_ICFG:   rdata_o = IMMU_CFG;
                SEL_NPC:    rdata_o = npc_o;
                SEL_STAT:   rdata_o = sr_o;
                SEL_PPC:    rdata_o = ppc_o;
                SEL_EPC:    rdata_o = epcr_o;
                SEL_EADDR:  rdata_o = eear_o;
                SEL_ESTAT:  rdata_o = esr_o;
                SEL_ACC_LO: rdata_o = mac_o[XLEN-1:0];
                SEL_ACC_HI: rdata_o = mac_o[ACC_W-1:XLEN];
                SEL_IMASK:  rdata_o = pic_mask_o;
                SEL_IPEND:  rdata_o = pic_stat_o;
                default:    rdata_o = prev_rd_i;
            endcase
        end
    end
endmodule

// File: rtl/spr_unit_checks.sv
module spr_unit_checks (
    input logic        clk,
    input logic        rst,
    input logic        rd_en_i,
    input logic        wr_en_i,
    input logic [31:0] base_i,
    input logic [15:0] imm_i,
    input logic [31:0] wdata_i,
    input logic [31:0] prev_rd_i,
    input logic [31:0] irq_set_i,
    input logic [31:0] rdata_o,
    input logic        flush_o,
    input logic [31:0] sr_o,
    input logic [63:0] mac_o,
    input logic [31:0] pic_mask_o,
    input logic [31:0] pic_stat_o
);
    logic [31:0] num;
    assign num = base_i | {16'h0000, imm_i};

    assert_miss_passthru_R8: assert property (@(posedge clk) disable iff (rst)
        (!rd_en_i || num[31:16] != 16'h0000) |-> (rdata_o == prev_rd_i));

    assert_mask_keeps_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pic_mask_o & $past(pic_mask_o)) == $past(pic_mask_o)));

    assert_pend_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && num == 32'h0000_4802) |=>
        ((pic_stat_o & $past(wdata_i) & ~$past(irq_set_i)) == 32'h0));

    assert_acc_hi_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && num == 32'h0000_2801) |=> (mac_o[63:32] == $past(mac_o[63:32])));

    assert_acc_lo_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && num == 32'h0000_2802) |=> (mac_o[31:0] == $past(mac_o[31:0])));

    assert_flush_cause_R7: assert property (@(posedge clk) disable iff (rst)
        flush_o |-> $past(wr_en_i && num == 32'h0000_0011 &&
                          ((sr_o ^ wdata_i) & 32'h0000_0061) != 32'h0));

    assert_sr_reset_R9: assert property (@(posedge clk)
        rst |=> (sr_o == 32'h0000_0001 && !flush_o));
endmodule

bind spr_unit spr_unit_checks u_checks (
    .clk        (clk),
    .rst        (rst),
    .rd_en_i    (rd_en_i),
    .wr_en_i    (wr_en_i),
    .base_i     (base_i),
    .imm_i      (imm_i),
    .wdata_i    (wdata_i),
    .prev_rd_i  (prev_rd_i),
    .irq_set_i  (irq_set_i),
    .rdata_o    (rdata_o),
    .flush_o    (flush_o),
    .sr_o       (sr_o),
    .mac_o      (mac_o),
    .pic_mask_o (pic_mask_o),
    .pic_stat_o (pic_stat_o)
);

// File: tb/spr_unit_bench.sv
`timescale 1ns/1ps
module spr_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_en_i = 1'b0, wr_en_i = 1'b0;
    logic [31:0] base_i = '0, wdata_i = '0, prev_rd_i = '0, irq_set_i = '0;
    logic [15:0] imm_i = '0;
    logic [31:0] rdata_o, sr_o, npc_o, ppc_o, epcr_o, eear_o, esr_o, pic_mask_o, pic_stat_o;
    logic [63:0] mac_o;
    logic        flush_o;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    // Reference state
    logic [31:0] m_sr, m_npc, m_ppc, m_epc, m_eaddr, m_estat, m_mask, m_pend;
    logic [63:0] m_acc;
    logic        m_flush;

    always #2.5 clk = ~clk;

    spr_unit u_spr_unit (
        .clk(clk), .rst(rst), .rd_en_i(rd_en_i), .wr_en_i(wr_en_i),
        .base_i(base_i), .imm_i(imm_i), .wdata_i(wdata_i), .prev_rd_i(prev_rd_i),
        .irq_set_i(irq_set_i), .rdata_o(rdata_o), .flush_o(flush_o), .sr_o(sr_o),
        .npc_o(npc_o), .ppc_o(ppc_o), .epcr_o(epcr_o), .eear_o(eear_o), .esr_o(esr_o),
        .mac_o(mac_o), .pic_mask_o(pic_mask_o), .pic_stat_o(pic_stat_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_read(input logic rd, input logic [31:0] n,
                                             input logic [31:0] prev);
        if (!rd || n[31:16] != 16'h0) return prev;
        case (n[15:0])
            16'h0000: return 32'h1200_0007;
            16'h0001: return 32'h0000_0619;
            16'h0002: return 32'h0000_0020;
            16'h0003: return 32'h0000_0018;
            16'h0004: return 32'h0000_0018;
            16'h0010: return m_npc;
            16'h0011: return m_sr;
            16'h0012: return m_ppc;
            16'h0020: return m_epc;
            16'h0030: return m_eaddr;
            16'h0040: return m_estat;
            16'h2801: return m_acc[31:0];
            16'h2802: return m_acc[63:32];
            16'h4800: return m_mask;
            16'h4802: return m_pend;
            default:  return prev;
        endcase
    endfunction

    task automatic ref_reset();
        m_sr = 32'h1; m_npc = '0; m_ppc = '0; m_epc = '0; m_eaddr = '0; m_estat = '0;
        m_mask = '0; m_pend = '0; m_acc = '0; m_flush = 1'b0;
    endtask

    task automatic ref_edge(input logic wr, input logic [31:0] n, input logic [31:0] d,
                            input logic [31:0] irq);
        logic [31:0] clr = '0;
        m_flush = 1'b0;
        if (wr && n[31:16] == 16'h0) begin
            case (n[15:0])
                16'h0010: m_npc = d;
                16'h0011: begin m_flush = ((m_sr ^ d) & 32'h61) != 0; m_sr = d; end
                16'h0012: m_ppc = d;
                16'h0020: m_epc = d;
                16'h0030: m_eaddr = d;
                16'h0040: m_estat = d;
                16'h2801: m_acc[31:0] = d;
                16'h2802: m_acc[63:32] = d;
                16'h4800: m_mask = m_mask | d;
                16'h4802: clr = d;
                default: ;
            endcase
        end
        m_pend = (m_pend & ~clr) | irq;
    endtask

    task automatic cmp_state();
        chk("R3 status", 64'(sr_o), 64'(m_sr));
        chk("R3 npc", 64'(npc_o), 64'(m_npc));
        chk("R3 ppc", 64'(ppc_o), 64'(m_ppc));
        chk("R3 epc", 64'(epcr_o), 64'(m_epc));
        chk("R3 eaddr", 64'(eear_o), 64'(m_eaddr));
        chk("R3 estat", 64'(esr_o), 64'(m_estat));
        chk("R4 acc", mac_o, m_acc);
        chk("R5 mask", 64'(pic_mask_o), 64'(m_mask));
        chk("R6 pend", 64'(pic_stat_o), 64'(m_pend));
        chk("R7 flush", 64'(flush_o), 64'(m_flush));
    endtask

    // One operation: drive at negedge, check read, clock, check state.
    task automatic op(input logic rd, input logic wr, input logic [31:0] b,
                      input logic [15:0] im, input logic [31:0] d,
                      input logic [31:0] prev, input logic [31:0] irq);
        logic [31:0] n = b | {16'h0, im};
        rd_en_i = rd; wr_en_i = wr; base_i = b; imm_i = im; wdata_i = d;
        prev_rd_i = prev; irq_set_i = irq;
        #1;
        chk("R10 read", 64'(rdata_o), 64'(ref_read(rd, n, prev)));
        @(posedge clk);
        ref_edge(wr, n, d, irq);
        @(negedge clk);
        cmp_state();
    endtask

    task automatic wr_op(input logic [15:0] n, input logic [31:0] d);
        op(1'b0, 1'b1, 32'h0, n, d, 32'hDEAD_0000, 32'h0);
    endtask

    task automatic rd_op(input string tag, input logic [31:0] b, input logic [15:0] im,
                         input logic [31:0] prev, input logic [31:0] exp);
        rd_en_i = 1'b1; wr_en_i = 1'b0; base_i = b; imm_i = im;
        prev_rd_i = prev; irq_set_i = 32'h0;
        #1;
        chk(tag, 64'(rdata_o), 64'(exp));
        @(posedge clk);
        ref_edge(1'b0, 32'h0, 32'h0, 32'h0);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        ref_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        chk("R9 reset status", 64'(sr_o), 64'h1);
        chk("R9 reset flush", 64'(flush_o), 64'h0);
        chk("R9 reset acc", mac_o, 64'h0);
        cmp_state();

        // R2: constants and masked version
        rd_op("R2 version masked", 32'h0, 16'h0000, 32'h5, 32'h1200_0007);
        rd_op("R2 unit present", 32'h0, 16'h0001, 32'h5, 32'h0000_0619);
        rd_op("R2 dmmu config", 32'h0, 16'h0003, 32'h5, 32'h0000_0018);
        // R8: read-only write ignored
        wr_op(16'h0000, 32'hFFFF_FFFF);
        rd_op("R8 version after write", 32'h0, 16'h0000, 32'h5, 32'h1200_0007);

        // R1: OR vs sum (1|0x11 = 0x11 status, sum would be 0x12)
        wr_op(16'h0012, 32'hAAAA_0001);
        rd_op("R1 or-formed number", 32'h1, 16'h0011, 32'h5, 32'h0000_0001);
        // R1/R8: upper bits set -> unmapped
        rd_op("R1 upper bits unmapped", 32'h0001_0000, 16'h0011, 32'h7777_1234, 32'h7777_1234);
        rd_op("R8 unmapped group", 32'h0, 16'h5000, 32'h0BAD_CAFE, 32'h0BAD_CAFE);
        op(1'b0, 1'b1, 32'h0001_0000, 16'h0040, 32'h1111_2222, 32'h0, 32'h0);
        chk("R8 unmapped write no effect", 64'(esr_o), 64'h0);

        // R4: half deposits
        wr_op(16'h2801, 32'h0123_4567);
        wr_op(16'h2802, 32'h89AB_CDEF);
        wr_op(16'h2801, 32'hFFFF_0000);
        chk("R4 accumulator halves", mac_o, 64'h89AB_CDEF_FFFF_0000);

        // R5: OR-set sequence
        wr_op(16'h4800, 32'h0000_00F0);
        wr_op(16'h4800, 32'h0000_0003);
        wr_op(16'h4800, 32'h0000_0000);
        chk("R5 mask accumulates", 64'(pic_mask_o), 64'h0000_00F3);

        // R6: pending set then clear, set wins in same cycle
        op(1'b0, 1'b0, 32'h0, 16'h0, 32'h0, 32'h0, 32'h0000_0F0F);
        op(1'b0, 1'b1, 32'h0, 16'h4802, 32'h0000_0303, 32'h0, 32'h0000_0001);
        chk("R6 clear with set", 64'(pic_stat_o), 64'h0000_0C0D);

        // R7: unprotected bit change -> no flush; protected bit -> one pulse
        wr_op(16'h0011, 32'h0000_8001);
        chk("R7 no flush unprotected", 64'(flush_o), 64'h0);
        wr_op(16'h0011, 32'h0000_8021);
        chk("R7 flush on dmmu", 64'(flush_o), 64'h1);
        op(1'b0, 1'b0, 32'h0, 16'h0, 32'h0, 32'h0, 32'h0);
        chk("R7 flush one cycle", 64'(flush_o), 64'h0);
        wr_op(16'h0011, 32'h0000_8021);
        chk("R7 same value no flush", 64'(flush_o), 64'h0);

        // R10: read and write same number in same cycle returns old value
        op(1'b1, 1'b1, 32'h0, 16'h0020, 32'h5555_AAAA, 32'h0, 32'h0);
        op(1'b1, 1'b0, 32'h0, 16'h0020, 32'h0, 32'h0, 32'h0);

        // Mixed random traffic, compared every clock
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] pick;
            case ($urandom_range(0, 17))
                0: pick = 16'h0000;  1: pick = 16'h0001;  2: pick = 16'h0002;
                3: pick = 16'h0004;  4: pick = 16'h0010;  5: pick = 16'h0011;
                6: pick = 16'h0011;  7: pick = 16'h0012;  8: pick = 16'h0020;
                9: pick = 16'h0030;  10: pick = 16'h0040; 11: pick = 16'h2801;
                12: pick = 16'h2802; 13: pick = 16'h4800; 14: pick = 16'h4802;
                15: pick = 16'h4802; 16: pick = 16'h5001;
                default: pick = 16'($urandom);
            endcase
            op(1'($urandom), 1'($urandom), ($urandom_range(0, 15) == 0) ? 32'h0002_0000 : 32'h0,
               pick, ($urandom_range(0, 1) == 0) ? ($urandom & 32'h0000_8061) : $urandom,
               $urandom, $urandom & $urandom & $urandom);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule